// File: doc/BRIEF.md
# Mark-Inversion Line Decoder with Nibble Output

This block takes a serial line coded with Coded Mark Inversion (CMI) and turns it back into plain NRZ data. It runs on a clock at twice the bit rate, so each bit period gives it two half-bit samples. It decodes one bit from each pair of samples. The same bits leave the block in two forms: as a retimed serial bit with a one-cycle bit strobe, and as a 4-bit parallel word with a one-cycle word strobe. The line rate can be either of the two common rates near 155 Mbit/s and 139 Mbit/s. The block runs the same way at both, since it only needs a clock at twice the bit rate.

With the mode input low, the block skips decoding and treats the line as NRZ data that is already decoded. In that case it takes one sample per bit period. A test input lets an external bit clock, sampled by the block, set the bit boundaries in place of the internal half-bit phase. A violation flag reports symbols that the CMI code does not allow. Bit-period alignment finds itself from the falling-edge pattern that never appears inside a valid symbol, and it slips by half a period after a run of such patterns.

Top module: `cmi_nib_decoder`

## Requirements
- R1: While `rstN` is low, `bitStb`, `nibbleStb`, `codeViol`, `nrzOut` and `nibbleOut` are all 0.
- R2: With `cmiEn`=1 and `testClkEn`=0, each bit period is decoded from its two half-bit samples. Samples low then high give 0, and two equal samples give 1. The bit appears on `nrzOut` in the cycle where `bitStb` is high. `bitStb` is never high for three cycles in a row.
- R3: With `cmiEn`=0 and `testClkEn`=0, the line is treated as NRZ held for two clock cycles per bit. The block takes one sample per bit, every second cycle, and `codeViol` stays 0.
- R4: Every 4 bit strobes, `nibbleStb` is high for one cycle, together with the strobe of the 4th bit. `nibbleOut` then holds those 4 bits, with the earliest in bit 3 and the latest (equal to `nrzOut`) in bit 0.
- R5: In CMI decoding, a bit period sampled high then low raises `codeViol` in the cycle of its bit strobe.
- R6: In CMI decoding, a 1 at the same level as the previous decoded 1 raises `codeViol`. After reset the first 1 is expected high.
- R7: Bit alignment moves by one half-bit period after 3 back-to-back bit periods sampled high then low. A single such period does not move the alignment.
- R8: With `testClkEn`=1, a bit is taken on each rising edge of `testClk` (after a two-stage sampler) as NRZ, whatever `cmiEn` is. Exactly one bit strobe comes per test-clock rising edge, and `codeViol` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit-period clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmiEn | input | 1 | 1: decode CMI, 0: pass NRZ through |
| testClkEn | input | 1 | 1: external bit clock sets the bit boundaries |
| testClk | input | 1 | External test bit clock |
| lineIn | input | 1 | Serial line sample |
| nrzOut | output | 1 | Retimed decoded serial bit |
| bitStb | output | 1 | One-cycle strobe marking a new `nrzOut` bit |
| nibbleOut | output | 4 | Last 4 decoded bits, earliest in MSB |
| nibbleStb | output | 1 | One-cycle strobe marking a completed nibble |
| codeViol | output | 1 | One-cycle flag for a disallowed CMI symbol |

## Verification
Two events can land in the same cycle. The strobe of a bit that is itself a violation can also be the 4th bit of a nibble. An alignment slip can put two bit strobes in consecutive cycles while a nibble is being assembled. The bench injects high-then-low symbols and level errors at several nibble positions, and it forces slips by adding a stray half-bit sample. It then checks that every nibble still equals the last four serial bits it captured, that exactly one violation is counted for each injected error, and that a 64-bit sweep of every 4-bit value is found intact in the captured stream after alignment returns.

// File: rtl/cmi_nib_pkg.sv
package cmi_nib_pkg;
  // Strobes from the control section to the datapath
  typedef struct packed {
    logic takeBit;  // current sample pair closes a bit period
    logic cmiMode;  // decode CMI (else NRZ sampling)
  } ctrlStb_t;
endpackage

// File: rtl/cmi_nib_ctrl.sv
module cmi_nib_ctrl
  import cmi_nib_pkg::*;
#(
  parameter int SLIP_RUN = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmiEn,
  input  logic     testClkEn,
  input  logic     testClk,
  input  logic     hlSeen,
  output ctrlStb_t stb
);
  localparam int RUN_W = $clog2(SLIP_RUN + 1);

  logic             phase;
  logic             tcQ1, tcQ2;
  logic             tcRise;
  logic             slipNow;
  logic [RUN_W-1:0] runCnt;

  always_comb begin
    tcRise      = tcQ1 & ~tcQ2;
    stb.cmiMode = cmiEn & ~testClkEn;
    stb.takeBit = testClkEn ? tcRise : phase;
    slipNow     = stb.takeBit & stb.cmiMode & hlSeen &
                  (runCnt == RUN_W'(SLIP_RUN - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= 1'b0;
      tcQ1   <= 1'b0;
      tcQ2   <= 1'b0;
      runCnt <= '0;
    end else begin
      tcQ1  <= testClk;
      tcQ2  <= tcQ1;
      // a slip holds the phase so the next pair is shifted by one sample
      phase <= slipNow ? 1'b1 : ~phase;
      if (stb.takeBit && stb.cmiMode) begin
        if (!hlSeen || slipNow) runCnt <= '0;
        else                    runCnt <= runCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmi_nib_datapath.sv
module cmi_nib_datapath
  import cmi_nib_pkg::*;
#(
  parameter int NIB_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineIn,
  input  ctrlStb_t            stb,
  output logic                hlSeen,
  output logic                nrzOut,
  output logic                bitStb,
  output logic [NIB_BITS-1:0] nibbleOut,
  output logic                nibbleStb,
  output logic                codeViol
);
  localparam int CNT_W = $clog2(NIB_BITS);

  logic                sampReg, prevSamp, lastLvl;
  logic                bitVal, viol;
  logic [NIB_BITS-2:0] nibShift;
  logic [NIB_BITS-1:0] nextNib;
  logic [CNT_W-1:0]    bitCnt;

  always_comb begin
    hlSeen = prevSamp & ~sampReg;
    if (stb.cmiMode) begin
      bitVal = (prevSamp == sampReg);
      viol   = hlSeen | (bitVal & (sampReg == lastLvl));
    end else begin
      bitVal = sampReg;
      viol   = 1'b0;
    end
    nextNib = {nibShift, bitVal};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampReg   <= 1'b0;
      prevSamp  <= 1'b0;
      lastLvl   <= 1'b0;
      nibShift  <= '0;
      bitCnt    <= '0;
      nrzOut    <= 1'b0;
      bitStb    <= 1'b0;
      nibbleOut <= '0;
      nibbleStb <= 1'b0;
      codeViol  <= 1'b0;
    end else begin
      sampReg   <= lineIn;
      prevSamp  <= sampReg;
      bitStb    <= stb.takeBit;
      codeViol  <= stb.takeBit & viol;
      nibbleStb <= 1'b0;
      if (stb.takeBit) begin
        nrzOut   <= bitVal;
        nibShift <= nextNib[NIB_BITS-2:0];
        if (stb.cmiMode && bitVal) lastLvl <= sampReg;
        if (bitCnt == CNT_W'(NIB_BITS - 1)) begin
          bitCnt    <= '0;
          nibbleOut <= nextNib;
          nibbleStb <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cmi_nib_decoder.sv
module cmi_nib_decoder
  import cmi_nib_pkg::*;
#(
  parameter int NIB_BITS = 4,
  parameter int SLIP_RUN = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmiEn,
  input  logic                testClkEn,
  input  logic                testClk,
  input  logic                lineIn,
  output logic                nrzOut,
  output logic                bitStb,
  output logic [NIB_BITS-1:0] nibbleOut,
  output logic                nibbleStb,
  output logic                codeViol
);
  ctrlStb_t stb;
  logic     hlSeen;

  cmi_nib_ctrl #(.SLIP_RUN(SLIP_RUN)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmiEn(cmiEn), .testClkEn(testClkEn),
    .testClk(testClk), .hlSeen(hlSeen), .stb(stb)
  );

  cmi_nib_datapath #(.NIB_BITS(NIB_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .stb(stb), .hlSeen(hlSeen),
    .nrzOut(nrzOut), .bitStb(bitStb), .nibbleOut(nibbleOut),
    .nibbleStb(nibbleStb), .codeViol(codeViol)
  );
endmodule

// File: rtl/cmi_nib_checker.sv
module cmi_nib_checker #(
  parameter int NIB_BITS = 4
) (
  input logic clk,
  input logic rstN,
  input logic cmiEn,
  input logic testClkEn,
  input logic nrzOut,
  input logic bitStb,
  input logic nibLsb,
  input logic nibbleStb,
  input logic codeViol
);
  localparam int SC_W = $clog2(NIB_BITS) + 1;
  logic [SC_W-1:0] bitsSince;

  always_ff @(posedge clk) begin
    if (!rstN) bitsSince <= '0;
    else if (bitStb) bitsSince <= nibbleStb ? '0 : bitsSince + 1'b1;
  end

  a_r2_bit_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (bitStb && $past(bitStb)) |=> !bitStb);

  a_r3_no_viol_nrz: assert property (@(posedge clk) disable iff (!rstN)
    (!cmiEn || testClkEn) |=> !codeViol);

  a_r4_nibble_count: assert property (@(posedge clk) disable iff (!rstN)
    nibbleStb |-> (bitsSince == SC_W'(NIB_BITS - 1)));

  a_r4_nibble_with_bit: assert property (@(posedge clk) disable iff (!rstN)
    nibbleStb |-> (bitStb && nibLsb == nrzOut));

  a_r5_viol_on_bit: assert property (@(posedge clk) disable iff (!rstN)
    codeViol |-> bitStb);

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(!rstN) |-> (!bitStb && !nibbleStb && !codeViol));
endmodule

bind cmi_nib_decoder cmi_nib_checker #(.NIB_BITS(NIB_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .cmiEn(cmiEn), .testClkEn(testClkEn),
  .nrzOut(nrzOut), .bitStb(bitStb), .nibLsb(nibbleOut[0]),
  .nibbleStb(nibbleStb), .codeViol(codeViol)
);

// File: tb/cmi_nib_decoder_tb.sv
module cmi_nib_decoder_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmiEn = 1'b1, testClkEn = 1'b0, testClk = 1'b0, lineIn = 1'b0;
  logic nrzOut, bitStb, nibbleStb, codeViol;
  logic [3:0] nibbleOut;

  int checks = 0, failures = 0;
  int capCount = 0, violCount = 0;
  logic capBits [0:4095];
  logic level = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmi_nib_decoder u_dut (
    .clk(clk), .rstN(rstN), .cmiEn(cmiEn), .testClkEn(testClkEn),
    .testClk(testClk), .lineIn(lineIn), .nrzOut(nrzOut), .bitStb(bitStb),
    .nibbleOut(nibbleOut), .nibbleStb(nibbleStb), .codeViol(codeViol)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // capture serial bits and verify each nibble against them (R4)
  always @(negedge clk) begin
    if (rstN) begin
      if (bitStb && capCount < 4096) begin
        capBits[capCount] = nrzOut;
        capCount++;
      end
      if (nibbleStb && capCount >= 4) begin
        logic [3:0] expNib;
        expNib = {capBits[capCount-4], capBits[capCount-3],
                  capBits[capCount-2], capBits[capCount-1]};
        chk(nibbleOut == expNib && bitStb, "R4 nibble", nibbleOut, expNib);
      end
      if (codeViol) violCount++;
    end
  end

  function automatic logic sweepBit(int i);
    return 1'((i / 4) >> (3 - (i % 4)));
  endfunction

  function automatic int findSweep(int from);
    for (int s = from; s + 64 <= capCount; s++) begin
      bit ok = 1'b1;
      for (int i = 0; i < 64; i++)
        if (capBits[s+i] != sweepBit(i)) begin ok = 1'b0; break; end
      if (ok) return 1;
    end
    return 0;
  endfunction

  task automatic half(input logic v);
    @(negedge clk);
    lineIn = v;
  endtask

  task automatic sendCmi(input logic b);
    if (b) begin level = ~level; half(level); half(level); end
    else begin half(1'b0); half(1'b1); end
  endtask

  task automatic sendNrz(input logic b);
    half(b); half(b);
  endtask

  task automatic preamble();
    for (int i = 0; i < 10; i++) sendCmi(1'b0);
    for (int i = 0; i < 4; i++) sendCmi(1'b1);
  endtask

  task automatic flush();
    for (int i = 0; i < 6; i++) sendCmi(1'b0);
  endtask

  task automatic cmiSweep(input string req);
    int mark, vMark;
    mark = capCount; vMark = violCount;
    for (int i = 0; i < 64; i++) sendCmi(sweepBit(i));
    flush();
    chk(findSweep(mark) == 1, req, findSweep(mark), 1);
    chk(violCount == vMark, {req, " no violation"}, violCount - vMark, 0);
  endtask

  initial begin
    int vMark, mark;
    repeat (3) @(negedge clk);
    chk(!bitStb && !nibbleStb && !codeViol && !nrzOut && nibbleOut == 4'd0,
        "R1 reset outputs", {bitStb, nibbleStb, codeViol, nrzOut, nibbleOut}, 0);
    rstN = 1'b1;

    // R2: decode after alignment, all 4-bit values
    preamble();
    cmiSweep("R2 cmi sweep");

    // R5: single high-then-low symbol
    vMark = violCount;
    half(1'b1); half(1'b0);
    flush();
    chk(violCount - vMark == 1, "R5 high-low violation", violCount - vMark, 1);
    // R7: a single such symbol leaves alignment intact
    cmiSweep("R7 no slip after single");

    // R6: repeated level on consecutive ones
    vMark = violCount;
    sendCmi(1'b1);
    half(level); half(level);
    sendCmi(1'b0); sendCmi(1'b1); flush();
    chk(violCount - vMark == 1, "R6 level violation", violCount - vMark, 1);
    cmiSweep("R6 after level error");

    // R7: stray half sample misaligns, zeros realign
    vMark = violCount;
    half(1'b0);
    preamble();
    chk(violCount - vMark >= 3, "R7 misalign seen", violCount - vMark, 3);
    cmiSweep("R7 realigned sweep");

    // R3: NRZ pass-through
    cmiEn = 1'b0;
    for (int i = 0; i < 4; i++) sendNrz(1'b0);
    mark = capCount; vMark = violCount;
    for (int i = 0; i < 64; i++) sendNrz(sweepBit(i));
    for (int i = 0; i < 4; i++) sendNrz(1'b0);
    chk(findSweep(mark) == 1, "R3 nrz sweep", findSweep(mark), 1);
    chk(violCount == vMark, "R3 nrz no violation", violCount - vMark, 0);

    // R8: external test clock, cmiEn high but ignored
    cmiEn = 1'b1;
    @(negedge clk); testClk = 1'b0; testClkEn = 1'b1;
    repeat (4) @(negedge clk);
    mark = capCount; vMark = violCount;
    for (int i = 0; i < 64; i++) begin
      testClk = 1'b0; lineIn = sweepBit(i);
      repeat (3) @(negedge clk);
      testClk = 1'b1;
      repeat (3) @(negedge clk);
    end
    testClk = 1'b0;
    repeat (4) @(negedge clk);
    chk(capCount - mark == 64, "R8 one bit per edge", capCount - mark, 64);
    chk(findSweep(mark) == 1, "R8 test clock sweep", findSweep(mark), 1);
    chk(violCount == vMark, "R8 no violation", violCount - vMark, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule